// File: doc/BRIEF.md
# Vectored interrupt event controller

This block gathers interrupt events for a small 4-bit microcontroller core and turns the winning one into a program-memory vector address. Three sources feed it. The first is an overflow pulse from a clock divider. The second is an underflow pulse from a timer. The third is a change on any enabled pin of a four-pin input port. Each source sets its own sticky event flag. A request goes to the core only when three conditions hold together: the flag is set, the matching enable bit is set, and a single global enable latch is armed.

The core's instruction decoder drives the block through one-cycle strobes:

- arm the global enable;
- disarm the global enable;
- load the per-source enable register, which also arms the global enable;
- load the pin mask;
- clear a chosen set of event flags.

When a request is accepted, the block emits a one-cycle strobe with the vector. It then disarms itself so that the service routine runs without being interrupted. Fetch, stacking and return are left to the core.

Flag positions are fixed: the divider uses bit 0, the timer uses bit 2 and the port uses bit 7. Each vector is 0x004 plus four times the bit position.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the strobe is low, the vector output reads 0x000, and all flags, enables, the pin mask and the global enable are clear. A source event that arrives before software enables anything raises no strobe.
- R2: A divider pulse sampled at clock edge k sets flag bit 0. With enable bit 0 and the global enable armed, `irq_o` is high for exactly one cycle after edge k+1, with `vec_o` = 0x004.
- R3: A timer pulse sets flag bit 2 and gives vector 0x00C. A port event sets flag bit 7 and gives vector 0x020. No other vector value ever appears with the strobe.
- R4: A port event occurs when any pin whose pin-mask bit is 1 differs from its value at the previous clock edge, rising or falling. Changes on pins whose mask bit is 0 set no flag.
- R5: A set flag raises no request while its enable bit (bit 0, 2 or 7 of the enable register) is 0. A later enable-register load that sets that bit raises the request.
- R6: When several enabled flags are pending, the one with the lowest bit position is served first.
- R7: Each accepted request disarms the global enable in the same cycle. No further strobe occurs until an arm strobe or an enable-register load re-arms it, so two strobes are never back to back.
- R8: A disarm strobe clears the global enable. It wins over an arm strobe or an enable-register load in the same cycle.
- R9: The flag-clear strobe clears the flags whose mask bits are 1. An accepted flag stays set until software clears it. A source event in the same cycle as a clear of its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ovf_i | input | 1 | Divider overflow pulse |
| tmr_unf_i | input | 1 | Timer underflow pulse |
| port_pins_i | input | PORT_W | Level of the watched port pins |
| en_int_i | input | 1 | Arm-global-enable strobe |
| dis_int_i | input | 1 | Disarm-global-enable strobe |
| ie_wr_i | input | 1 | Enable-register load strobe (also arms) |
| ie_data_i | input | 8 | Enable-register value, bits 0/2/7 used |
| pm_wr_i | input | 1 | Pin-mask load strobe |
| pm_data_i | input | PORT_W | Pin-mask value |
| clr_i | input | 1 | Flag-clear strobe |
| clr_mask_i | input | 8 | Flags to clear, one bit per flag position |
| irq_o | output | 1 | One-cycle request strobe |
| vec_o | output | ADDR_W | Vector of the accepted request, held between strobes |

## Verification
The bench runs every combination of pending sources against every enable mask. A wrong priority encoder would give the wrong vector, and a missing enable gate would raise strobes that should be masked. After each strobe the bench holds off re-arming. A design that does not disarm itself would strobe twice, and one that clears the accepted flag would stay silent once re-armed. The port part covers every pin and mask value in both toggle directions, which exposes edge detection that ignores the mask or sees only one direction. Directed cases cover arm against disarm in the same cycle, event against clear in the same cycle, and events that arrive before anything is enabled.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned DIV_BIT  = 0;
  localparam int unsigned TMR_BIT  = 2;
  localparam int unsigned PORT_BIT = 7;
  localparam logic [FLAG_W-1:0] SRC_MASK =
    FLAG_W'((1 << DIV_BIT) | (1 << TMR_BIT) | (1 << PORT_BIT));
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
  import irq_vec_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_ovf,
  input  logic              tmr_unf,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] pmask,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] flags
);
  logic [PORT_W-1:0] pins_q;
  logic              port_evt;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] kept;

  assign port_evt = |((pins ^ pins_q) & pmask);

  always_comb begin
    set_vec           = '0;
    set_vec[DIV_BIT]  = div_ovf;
    set_vec[TMR_BIT]  = tmr_unf;
    set_vec[PORT_BIT] = port_evt;
    kept = clr_en ? (flags & ~clr_mask) : flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      flags  <= '0;
    end else begin
      pins_q <= pins;
      flags  <= (kept | set_vec) & SRC_MASK;
    end
  end
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
  import irq_vec_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_wr,
  input  logic [FLAG_W-1:0] ie_data,
  input  logic              pm_wr,
  input  logic [PORT_W-1:0] pm_data,
  input  logic              en_int,
  input  logic              dis_int,
  input  logic              accept,
  output logic [FLAG_W-1:0] ie,
  output logic [PORT_W-1:0] pmask,
  output logic              gie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie    <= '0;
      pmask <= '0;
      gie   <= 1'b0;
    end else begin
      if (ie_wr) ie    <= ie_data & SRC_MASK;
      if (pm_wr) pmask <= pm_data;
      if (accept || dis_int)   gie <= 1'b0;
      else if (en_int || ie_wr) gie <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec
  import irq_vec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] ie,
  input  logic              gie,
  output logic              accept,
  output logic [ADDR_W-1:0] vec
);
  logic [FLAG_W-1:0] live;
  logic [ADDR_W-1:0] slot_addr [FLAG_W];

  assign live   = flags & ie;
  assign accept = gie && (|live);

  for (genvar g = 0; g < FLAG_W; g++) begin : g_slot
    assign slot_addr[g] = ADDR_W'(VEC_BASE + VEC_STEP * g);
  end

  always_comb begin
    vec = '0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (live[i]) vec = slot_addr[i];
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned PORT_W   = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_ovf_i,
  input  logic              tmr_unf_i,
  input  logic [PORT_W-1:0] port_pins_i,
  input  logic              en_int_i,
  input  logic              dis_int_i,
  input  logic              ie_wr_i,
  input  logic [7:0]        ie_data_i,
  input  logic              pm_wr_i,
  input  logic [PORT_W-1:0] pm_data_i,
  input  logic              clr_i,
  input  logic [7:0]        clr_mask_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] ie;
  logic [PORT_W-1:0] pmask;
  logic              gie;
  logic              accept;
  logic [ADDR_W-1:0] vec_next;

  irq_event_latch #(.PORT_W(PORT_W)) u_evt (
    .clk(clk), .rst(rst), .div_ovf(div_ovf_i), .tmr_unf(tmr_unf_i),
    .pins(port_pins_i), .pmask(pmask), .clr_en(clr_i),
    .clr_mask(clr_mask_i), .flags(flags)
  );

  irq_enable_ctl #(.PORT_W(PORT_W)) u_en (
    .clk(clk), .rst(rst), .ie_wr(ie_wr_i), .ie_data(ie_data_i),
    .pm_wr(pm_wr_i), .pm_data(pm_data_i), .en_int(en_int_i),
    .dis_int(dis_int_i), .accept(accept), .ie(ie), .pmask(pmask), .gie(gie)
  );

  irq_prio_vec #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_pv (
    .flags(flags), .ie(ie), .gie(gie), .accept(accept), .vec(vec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= accept;
      if (accept) vec_o <= vec_next;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              en_int_i,
  input logic              dis_int_i,
  input logic              ie_wr_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] vec_o
);
  // R1: reset leaves outputs quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && vec_o == '0));

  // R2: vector only moves together with a strobe
  p_vec_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> $stable(vec_o));

  // R3: only the three legal vectors accompany a strobe
  p_vec_legal_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_o == ADDR_W'(4) || vec_o == ADDR_W'(12) || vec_o == ADDR_W'(32)));

  // R7: strobe lasts one cycle
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R7: without a re-arm the next strobe cannot follow
  p_needs_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !en_int_i && !ie_wr_i) |=> ##1 !irq_o);

  // R8: disarm blocks any strobe two edges later
  p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
    dis_int_i |=> ##1 !irq_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .en_int_i(en_int_i), .dis_int_i(dis_int_i),
  .ie_wr_i(ie_wr_i), .irq_o(irq_o), .vec_o(vec_o)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  localparam int PW = 4;
  localparam int AW = 12;

  logic          clk = 0;
  logic          rst = 1;
  logic          div_ovf_i = 0, tmr_unf_i = 0;
  logic [PW-1:0] port_pins_i = '0;
  logic          en_int_i = 0, dis_int_i = 0, ie_wr_i = 0, pm_wr_i = 0, clr_i = 0;
  logic [7:0]    ie_data_i = '0, clr_mask_i = '0;
  logic [PW-1:0] pm_data_i = '0;
  logic          irq_o;
  logic [AW-1:0] vec_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .div_ovf_i(div_ovf_i), .tmr_unf_i(tmr_unf_i),
    .port_pins_i(port_pins_i), .en_int_i(en_int_i), .dis_int_i(dis_int_i),
    .ie_wr_i(ie_wr_i), .ie_data_i(ie_data_i), .pm_wr_i(pm_wr_i),
    .pm_data_i(pm_data_i), .clr_i(clr_i), .clr_mask_i(clr_mask_i),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit exp_irq, input logic [AW-1:0] exp_vec, input string req);
    checks++;
    if (irq_o !== exp_irq || (exp_irq && vec_o !== exp_vec)) begin
      errors++;
      $display("FAIL %s: irq=%0b vec=%03h expected irq=%0b vec=%03h",
               req, irq_o, vec_o, exp_irq, exp_vec);
    end
  endtask

  task automatic idle();
    dis_int_i = 1; clr_i = 1; clr_mask_i = 8'hFF;
    tick();
    dis_int_i = 0; clr_i = 0; clr_mask_i = '0;
  endtask

  task automatic write_pm(input logic [PW-1:0] m);
    pm_wr_i = 1; pm_data_i = m;
    tick();
    pm_wr_i = 0;
  endtask

  task automatic write_ie(input logic [7:0] m);
    ie_wr_i = 1; ie_data_i = m;
    tick();
    ie_wr_i = 0;
  endtask

  task automatic arm();
    en_int_i = 1;
    tick();
    en_int_i = 0;
  endtask

  function automatic logic [AW-1:0] vec_of(input int idx);
    return AW'(4 + 4 * idx);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 0;
    #1;
    // R1: reset state
    chk(0, '0, "R1 reset");
    checks++;
    if (vec_o !== '0) begin
      errors++;
      $display("FAIL R1: vec=%03h expected 000", vec_o);
    end
    // R1: events before any enable
    div_ovf_i = 1; tmr_unf_i = 1; tick(); div_ovf_i = 0; tmr_unf_i = 0;
    tick(); tick();
    chk(0, '0, "R1 events before enable");
    // R5: armed but enable bit clear
    arm(); tick();
    chk(0, '0, "R5 no enable bit");
    // R5: enable bit 0 loaded afterwards, flag 0 wins (R6)
    write_ie(8'h01); tick();
    chk(1, vec_of(0), "R5 late enable");

    // R6/R7/R9: sweep every pending set against every enable mask
    write_pm(4'h1);
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        int hit;
        int win;
        logic [7:0] iem;
        idle();
        div_ovf_i = p[0]; tmr_unf_i = p[1];
        if (p[2]) port_pins_i[0] = ~port_pins_i[0];
        tick();
        div_ovf_i = 0; tmr_unf_i = 0;
        iem = 8'((m & 1) | ((m & 2) << 1) | ((m & 4) << 5));
        write_ie(iem);
        tick();
        hit = p & m;
        win = (hit & 1) ? 0 : (hit & 2) ? 2 : 7;
        if (hit != 0) chk(1, vec_of(win), "R6 priority sweep");
        else          chk(0, '0, "R5 masked sweep");
        tick();
        chk(0, '0, "R7 strobe one cycle");
        tick();
        chk(0, '0, "R7 stays disarmed");
        if (hit != 0) begin
          arm(); tick();
          chk(1, vec_of(win), "R9 flag not auto-cleared");
        end
      end
    end

    // R4/R3: every pin against every mask, both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int pin = 0; pin < PW; pin++) begin
        for (int m = 0; m < 16; m++) begin
          idle();
          write_pm(PW'(m));
          port_pins_i[pin] = ~port_pins_i[pin];
          tick();
          write_ie(8'h80);
          tick();
          chk(m[pin], vec_of(7), "R4 pin mask sweep");
        end
      end
    end
    write_pm(4'h1);

    // R2/R3: single sources with timing
    idle(); write_ie(8'h85);
    div_ovf_i = 1; tick(); div_ovf_i = 0;
    chk(0, '0, "R2 not before edge k+1");
    tick();
    chk(1, vec_of(0), "R2 divider vector");
    idle(); write_ie(8'h85);
    tmr_unf_i = 1; tick(); tmr_unf_i = 0; tick();
    chk(1, vec_of(2), "R3 timer vector");

    // R8: disarm beats a same-cycle enable-register load and arm
    idle();
    div_ovf_i = 1; tick(); div_ovf_i = 0;
    ie_wr_i = 1; ie_data_i = 8'h01; dis_int_i = 1; en_int_i = 1;
    tick();
    ie_wr_i = 0; dis_int_i = 0; en_int_i = 0;
    tick();
    chk(0, '0, "R8 disarm wins");
    tick();
    chk(0, '0, "R8 still disarmed");
    arm(); tick();
    chk(1, vec_of(0), "R8 re-armed");

    // R9: event and clear in the same cycle keep the flag
    idle();
    div_ovf_i = 1; clr_i = 1; clr_mask_i = 8'h01;
    tick();
    div_ovf_i = 0; clr_i = 0; clr_mask_i = '0;
    arm(); tick();
    chk(1, vec_of(0), "R9 set beats clear");
    // R9: clear then re-arm yields nothing
    clr_i = 1; clr_mask_i = 8'h01; tick(); clr_i = 0; clr_mask_i = '0;
    arm(); tick();
    chk(0, '0, "R9 cleared flag");
    // R9: selective clear leaves timer flag
    idle(); write_ie(8'h85);
    dis_int_i = 1; div_ovf_i = 1; tmr_unf_i = 1; tick();
    dis_int_i = 0; div_ovf_i = 0; tmr_unf_i = 0;
    clr_i = 1; clr_mask_i = 8'h01; tick(); clr_i = 0; clr_mask_i = '0;
    arm(); tick();
    chk(1, vec_of(2), "R9 selective clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule